// File: doc/BRIEF.md
# Analog Input-Pair Conversion Sequencer

This block runs the conversion of one pair of analog inputs through a single converter. One input of the pair owns a private sample-and-hold; the other relies on a sample-and-hold that several pairs share. When a trigger is accepted, the block fires the private capture at once. It then runs the two conversions back to back in the order chosen by an order control bit. A second control bit, together with a busy indication for the shared unit, fixes the cycle in which the shared sample-and-hold captures.

The converter is modelled by a counter that spends `CONV_CYCLES` clock cycles on each input. The block pulses a start strobe and drives the channel number at the start of each conversion. It raises a done strobe for the even or odd input as that input finishes, and a pair-complete strobe together with the second done. A trigger that arrives while a pair is in progress is remembered and served right after it. Both control bits are captured when a trigger is accepted. By default the even input owns the private sample-and-hold and the odd input uses the shared one. The parameter `SHR_ON_EVEN` swaps the two.

Top module: `adc_pair_seq`

## Requirements
- R1: While reset is held and the trigger is low, every output strobe (dedSample, shrSample, convStart, evenDone, oddDone, pairDone) is 0.
- R2: A trigger seen while idle is accepted in that cycle: dedSample is 1 in the same cycle, and convStart is 1 in the next cycle.
- R3: With orderIn = 0 at acceptance, the first conversion uses chanSel = 2*PAIR_IDX (even) and the second uses 2*PAIR_IDX+1 (odd). With orderIn = 1 the two are reversed. chanSel is valid in every convStart cycle.
- R4: Each conversion lasts CONV_CYCLES cycles. Its done strobe comes CONV_CYCLES-1 cycles after its convStart, the second convStart comes in the cycle after the first done, and the cycle after pairDone has no strobe except a new acceptance.
- R5: evenDone or oddDone pulses for one cycle at the end of the matching input's conversion, never both in one cycle. pairDone pulses together with the second done.
- R6: With seqSampIn = 0 and sharedBusy = 0 at acceptance, shrSample is 1 in the acceptance cycle together with dedSample, and in no other cycle of that pair.
- R7: With seqSampIn = 0 and sharedBusy = 1 at acceptance, shrSample is 0 in the acceptance cycle and 1 in the first convStart cycle only.
- R8: With seqSampIn = 1 at acceptance, shrSample is 1 only in the convStart cycle of the shared input's conversion. With the default assignment (odd input shared), that is the second conversion when orderIn = 0 and the first when orderIn = 1.
- R9: A trigger that arrives while a pair is converting is held. It is accepted in the cycle after pairDone, and several such triggers in one pair yield exactly one further pair.
- R10: Changes to orderIn, seqSampIn and sharedBusy after acceptance do not affect the channel order or the shrSample timing of the pair in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| trig | input | 1 | Conversion trigger for the pair |
| orderIn | input | 1 | 0: even input first, 1: odd input first |
| seqSampIn | input | 1 | 0: shared capture as early as possible, 1: shared capture at its own conversion start |
| sharedBusy | input | 1 | Shared sample-and-hold is busy with another conversion |
| dedSample | output | 1 | Capture strobe for the private sample-and-hold |
| shrSample | output | 1 | Capture strobe for the shared sample-and-hold |
| convStart | output | 1 | Start of one input's conversion |
| chanSel | output | CH_W | Channel number being converted |
| evenDone | output | 1 | Even input's conversion finished |
| oddDone | output | 1 | Odd input's conversion finished |
| pairDone | output | 1 | Both conversions of the pair finished |

## Verification
A wrong latched order bit or phase bit shows up in the first convStart cycle as the wrong chanSel, one cycle after acceptance. It also shows up CONV_CYCLES-1 cycles later as the wrong done strobe. A corrupted deferral flag or sampling-mode bit moves shrSample to the wrong cycle within the first conversion, or to the wrong one of the two conversion starts. A lost or doubled pending trigger is visible in the cycle after pairDone, as a missing or extra dedSample. A miscounted converter model shifts every done strobe and the second convStart.

// File: rtl/adc_pair_seq_pkg.sv
`timescale 1ns/1ps
package adc_pair_seq_pkg;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_CONV = 1'b1
  } seqState_e;

  // strobes from control to datapath
  typedef struct packed {
    logic accept;     // take a new pair, latch configuration
    logic pendSet;    // trigger seen while converting
    logic cntRun;     // advance the converter model
    logic phaseFlip;  // first conversion ends, move to second
  } seqStrobe_t;

  // state reported by the datapath
  typedef struct packed {
    logic ordQ;
    logic seqQ;
    logic deferQ;
    logic pendQ;
    logic cntFirst;
    logic cntLast;
    logic phase;
  } seqStat_t;

endpackage

// File: rtl/adc_pair_seq_dp.sv
`timescale 1ns/1ps
module adc_pair_seq_dp
  import adc_pair_seq_pkg::*;
#(
  parameter int CONV_CYCLES = 4
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       orderIn,
  input  logic       seqSampIn,
  input  logic       sharedBusy,
  input  seqStrobe_t stb,
  output seqStat_t   stat
);

  localparam int CNT_W = (CONV_CYCLES < 2) ? 1 : $clog2(CONV_CYCLES);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(CONV_CYCLES - 1);

  logic [CNT_W-1:0] cnt;
  logic ordQ, seqQ, deferQ, pendQ, phase;

  // configuration captured once per pair
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ordQ   <= 1'b0;
      seqQ   <= 1'b0;
      deferQ <= 1'b0;
    end else if (stb.accept) begin
      ordQ   <= orderIn;
      seqQ   <= seqSampIn;
      deferQ <= !seqSampIn && sharedBusy;
    end
  end

  // held trigger
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)            pendQ <= 1'b0;
    else if (stb.accept)  pendQ <= 1'b0;
    else if (stb.pendSet) pendQ <= 1'b1;
  end

  // converter model: cycle counter and conversion phase
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cnt   <= '0;
      phase <= 1'b0;
    end else if (stb.accept) begin
      cnt   <= '0;
      phase <= 1'b0;
    end else if (stb.cntRun) begin
      if (cnt == CNT_LAST) cnt <= '0;
      else                 cnt <= cnt + 1'b1;
      if (stb.phaseFlip)   phase <= 1'b1;
    end
  end

  always_comb begin
    stat.ordQ     = ordQ;
    stat.seqQ     = seqQ;
    stat.deferQ   = deferQ;
    stat.pendQ    = pendQ;
    stat.cntFirst = (cnt == '0);
    stat.cntLast  = (cnt == CNT_LAST);
    stat.phase    = phase;
  end

endmodule

// File: rtl/adc_pair_seq_ctl.sv
`timescale 1ns/1ps
module adc_pair_seq_ctl
  import adc_pair_seq_pkg::*;
#(
  parameter int PAIR_IDX    = 1,
  parameter int CH_W        = 4,
  parameter bit SHR_ON_EVEN = 1'b0
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            trig,
  input  logic            seqSampIn,
  input  logic            sharedBusy,
  input  seqStat_t        stat,
  output seqStrobe_t      stb,
  output logic            dedSample,
  output logic            shrSample,
  output logic            convStart,
  output logic [CH_W-1:0] chanSel,
  output logic            evenDone,
  output logic            oddDone,
  output logic            pairDone
);

  localparam logic [CH_W-1:0] EVEN_CH = CH_W'(2 * PAIR_IDX);

  seqState_e state, stateNxt;
  logic inConv, accept, curIsOdd, curIsShared, convEnd;

  assign inConv   = (state == ST_CONV);
  assign accept   = (state == ST_IDLE) && (trig || stat.pendQ);
  assign curIsOdd = stat.phase ^ stat.ordQ;
  assign convEnd  = inConv && stat.cntLast;

  // which input uses the shared sample-and-hold
  generate
    if (SHR_ON_EVEN) begin : gShrEven
      assign curIsShared = !curIsOdd;
    end else begin : gShrOdd
      assign curIsShared = curIsOdd;
    end
  endgenerate

  always_comb begin
    stateNxt = state;
    case (state)
      ST_IDLE: if (accept) stateNxt = ST_CONV;
      ST_CONV: if (convEnd && stat.phase) stateNxt = ST_IDLE;
      default: stateNxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNxt;
  end

  always_comb begin
    stb.accept    = accept;
    stb.pendSet   = inConv && trig;
    stb.cntRun    = inConv;
    stb.phaseFlip = convEnd && !stat.phase;
  end

  always_comb begin
    dedSample = accept;
    convStart = inConv && stat.cntFirst;
    shrSample = (accept && !seqSampIn && !sharedBusy)
              | (convStart && !stat.phase && stat.deferQ)
              | (convStart && stat.seqQ && curIsShared);
    chanSel   = inConv ? (EVEN_CH | CH_W'(curIsOdd)) : EVEN_CH;
    evenDone  = convEnd && !curIsOdd;
    oddDone   = convEnd && curIsOdd;
    pairDone  = convEnd && stat.phase;
  end

endmodule

// File: rtl/adc_pair_seq.sv
`timescale 1ns/1ps
module adc_pair_seq
  import adc_pair_seq_pkg::*;
#(
  parameter int CONV_CYCLES = 4,
  parameter int PAIR_IDX    = 1,
  parameter int CH_W        = 4,
  parameter bit SHR_ON_EVEN = 1'b0
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            trig,
  input  logic            orderIn,
  input  logic            seqSampIn,
  input  logic            sharedBusy,
  output logic            dedSample,
  output logic            shrSample,
  output logic            convStart,
  output logic [CH_W-1:0] chanSel,
  output logic            evenDone,
  output logic            oddDone,
  output logic            pairDone
);

  seqStrobe_t stb;
  seqStat_t   stat;

  adc_pair_seq_dp #(
    .CONV_CYCLES(CONV_CYCLES)
  ) uDp (
    .clk       (clk),
    .rstN      (rstN),
    .orderIn   (orderIn),
    .seqSampIn (seqSampIn),
    .sharedBusy(sharedBusy),
    .stb       (stb),
    .stat      (stat)
  );

  adc_pair_seq_ctl #(
    .PAIR_IDX   (PAIR_IDX),
    .CH_W       (CH_W),
    .SHR_ON_EVEN(SHR_ON_EVEN)
  ) uCtl (
    .clk       (clk),
    .rstN      (rstN),
    .trig      (trig),
    .seqSampIn (seqSampIn),
    .sharedBusy(sharedBusy),
    .stat      (stat),
    .stb       (stb),
    .dedSample (dedSample),
    .shrSample (shrSample),
    .convStart (convStart),
    .chanSel   (chanSel),
    .evenDone  (evenDone),
    .oddDone   (oddDone),
    .pairDone  (pairDone)
  );

endmodule

// File: rtl/adc_pair_seq_chk.sv
`timescale 1ns/1ps
module adc_pair_seq_chk #(
  parameter int CONV_CYCLES = 4,
  parameter int PAIR_IDX    = 1,
  parameter int CH_W        = 4
) (
  input logic            clk,
  input logic            rstN,
  input logic            seqSampIn,
  input logic            sharedBusy,
  input logic            dedSample,
  input logic            shrSample,
  input logic            convStart,
  input logic [CH_W-1:0] chanSel,
  input logic            evenDone,
  input logic            oddDone,
  input logic            pairDone
);

  localparam logic [CH_W-1:0] EV = CH_W'(2 * PAIR_IDX);
  localparam logic [CH_W-1:0] OD = CH_W'(2 * PAIR_IDX + 1);

  int unsigned sinceStart;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                       sinceStart <= 0;
    else if (convStart)              sinceStart <= 0;
    else if (sinceStart != 32'hFFFF_FFFF) sinceStart <= sinceStart + 1;
  end

  a_r2_start_follows: assert property (@(posedge clk) disable iff (!rstN)
    dedSample |=> convStart);

  a_r3_chan_in_pair: assert property (@(posedge clk) disable iff (!rstN)
    convStart |-> (chanSel == EV || chanSel == OD));

  a_r4_conv_length: assert property (@(posedge clk) disable iff (!rstN)
    (evenDone || oddDone) |-> ((convStart ? 0 : sinceStart + 1) == CONV_CYCLES - 1));

  a_r4_idle_after_pair: assert property (@(posedge clk) disable iff (!rstN)
    pairDone |=> !convStart);

  a_r5_done_exclusive: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({evenDone, oddDone}));

  a_r5_pair_with_done: assert property (@(posedge clk) disable iff (!rstN)
    pairDone |-> (evenDone || oddDone));

  a_r6_simultaneous: assert property (@(posedge clk) disable iff (!rstN)
    (dedSample && !seqSampIn && !sharedBusy) |-> shrSample);

  a_r7_deferred: assert property (@(posedge clk) disable iff (!rstN)
    (dedSample && !seqSampIn && sharedBusy) |-> !shrSample);

endmodule

bind adc_pair_seq adc_pair_seq_chk #(
  .CONV_CYCLES(CONV_CYCLES),
  .PAIR_IDX   (PAIR_IDX),
  .CH_W       (CH_W)
) uChk (
  .clk       (clk),
  .rstN      (rstN),
  .seqSampIn (seqSampIn),
  .sharedBusy(sharedBusy),
  .dedSample (dedSample),
  .shrSample (shrSample),
  .convStart (convStart),
  .chanSel   (chanSel),
  .evenDone  (evenDone),
  .oddDone   (oddDone),
  .pairDone  (pairDone)
);

// File: tb/tb_adc_pair_seq.sv
`timescale 1ns/1ps
module tb_adc_pair_seq;

  localparam int N    = 4;
  localparam int PIDX = 1;
  localparam int CW   = 4;
  localparam int EVC  = 2 * PIDX;
  localparam int ODC  = 2 * PIDX + 1;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic trig = 1'b0, orderIn = 1'b0, seqSampIn = 1'b0, sharedBusy = 1'b0;
  logic dedSample, shrSample, convStart, evenDone, oddDone, pairDone;
  logic [CW-1:0] chanSel;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  adc_pair_seq #(.CONV_CYCLES(N), .PAIR_IDX(PIDX), .CH_W(CW)) dut (
    .clk(clk), .rstN(rstN), .trig(trig), .orderIn(orderIn),
    .seqSampIn(seqSampIn), .sharedBusy(sharedBusy),
    .dedSample(dedSample), .shrSample(shrSample), .convStart(convStart),
    .chanSel(chanSel), .evenDone(evenDone), .oddDone(oddDone), .pairDone(pairDone)
  );

  task automatic chk(input string tag, input string what, input int got, input int exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s %s: got %0d expected %0d at %0t", tag, what, got, exp, $time);
    end
  endtask

  // one pair, inputs optionally inverted after acceptance
  task automatic runPair(input bit ord, input bit seq, input bit busy, input bit flip);
    for (int k = 0; k <= 2 * N + 1; k++) begin
      bit secondPh, curOdd, isStart, isDone, expShr;
      string tShr, tChan;
      @(negedge clk);
      trig = (k == 0);
      if (k == 0) begin
        orderIn = ord; seqSampIn = seq; sharedBusy = busy;
      end else if (flip) begin
        orderIn = !ord; seqSampIn = !seq; sharedBusy = !busy;
      end
      #1;
      secondPh = (k >= N + 1);
      curOdd   = secondPh ^ ord;
      isStart  = (k == 1) || (k == N + 1);
      isDone   = (k == N) || (k == 2 * N);
      if (k == 0)          expShr = !seq && !busy;
      else if (k == 1)     expShr = seq ? ord : busy;
      else if (k == N + 1) expShr = seq && !ord;
      else                 expShr = 1'b0;
      tShr  = flip ? "R10" : (seq ? "R8" : (busy ? "R7" : "R6"));
      tChan = flip ? "R10" : "R3";
      chk("R2", "dedSample", dedSample, (k == 0));
      chk(tShr, "shrSample", shrSample, expShr);
      chk("R4", "convStart", convStart, isStart);
      if (isStart) chk(tChan, "chanSel", chanSel, curOdd ? ODC : EVC);
      chk("R5", "evenDone", evenDone, isDone && !curOdd);
      chk("R5", "oddDone", oddDone, isDone && curOdd);
      chk("R5", "pairDone", pairDone, (k == 2 * N));
    end
  endtask

  // triggers during conversion coalesce into one further pair
  task automatic runPending();
    orderIn = 1'b0; seqSampIn = 1'b0; sharedBusy = 1'b0;
    for (int k = 0; k <= 4 * N + 3; k++) begin
      @(negedge clk);
      trig = (k == 0) || (k == 3) || (k == 5);
      #1;
      chk("R9", "dedSample", dedSample, (k == 0) || (k == 2 * N + 1));
      chk("R9", "pairDone", pairDone, (k == 2 * N) || (k == 4 * N + 1));
      chk("R9", "convStart", convStart,
          (k == 1) || (k == N + 1) || (k == 2 * N + 2) || (k == 3 * N + 2));
    end
    trig = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    #1;
    chk("R1", "dedSample", dedSample, 0);
    chk("R1", "shrSample", shrSample, 0);
    chk("R1", "convStart", convStart, 0);
    chk("R1", "doneAny", evenDone | oddDone | pairDone, 0);
    @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    for (int f = 0; f < 2; f++)
      for (int o = 0; o < 2; o++)
        for (int s = 0; s < 2; s++)
          for (int b = 0; b < 2; b++)
            runPair(o[0], s[0], b[0], f[0]);
    runPending();
    repeat (2) @(negedge clk);
    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule